// File: doc/BRIEF.md
# Tile-Triggered CHR Bank Latch

This block lets the picture itself choose character-ROM banks. It watches every read that the video chip makes on its 14-bit fetch address bus. When the read hits one of two marker tiles, numbered 0xFD and 0xFE, a one-bit latch changes state. There is one latch for each 4 KB pattern table. Each latch chooses between two CPU-written bank registers. The chosen register drives CHR address lines 16..12 for whatever address the video chip is fetching at that moment. Software changes banks part-way through a frame by placing marker tiles in the background or in sprites, and needs no timed CPU code to do it.

The latch change is held back by two stages in series. The read that matched a marker tile, and the read that follows it, both still see the old bank. The new bank appears from the read after that. The two tables treat the tile's row bits differently:
- Table 0 reacts only to one exact byte of the marker tile.
- Table 1 reacts to any row of the marker tile's upper plane.

Top module: `chr_tile_latch`

## Requirements
- R1: Address bit 12 of the current fetch address picks the pattern table. `chr_bank` is combinational: it equals the bank register chosen by that table's latch for the address present in the same cycle. Changing one table's latch never changes the other table's latch.
- R2: A marker match compares address bits 11..4 with the tile number. A match on 0xFD drives the table's latch to the FD state (latch bit 0). A match on 0xFE drives it to the FE state (latch bit 1).
- R3: When address bit 13 is 1, no read ever triggers a latch change, whatever the state of the lower bits.
- R4: Table 0 (bit 12 = 0) triggers only when address bits 3..0 equal 0x8, which gives the exact addresses 0x0FD8 and 0x0FE8. Any other row or plane of the marker tile leaves the latch unchanged.
- R5: Table 1 (bit 12 = 1) triggers when bit 3 is 1, whatever bits 2..0 are, which gives 0x1FD8..0x1FDF and 0x1FE8..0x1FEF. Reads with bit 3 = 0 leave the latch unchanged.
- R6: The address is decoded only in cycles where `vid_rd` is high. A cycle with `vid_rd` low changes neither the latch nor the pending trigger.
- R7: A trigger is held in a pending stage. It updates the latch at the clock edge that ends the next `vid_rd` cycle, whatever address that read carries. If that next read is itself a marker match, it becomes the new pending trigger.
- R8: When `cpu_wr_en` is high, `cpu_wr_data` is stored in the register selected by `cpu_wr_sel`. Encoding: 0 = table 0 FD, 1 = table 0 FE, 2 = table 1 FD, 3 = table 1 FE. If that register is currently selected, the new value appears on `chr_bank` in the cycle after the write.
- R9: A synchronous active-high reset puts both latches in the FE state, clears all four bank registers to 0 and discards any pending trigger.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| vid_addr | input | 14 | Video fetch address |
| vid_rd | input | 1 | Video read strobe, one cycle per read |
| cpu_wr_en | input | 1 | Bank register write enable |
| cpu_wr_sel | input | 2 | Bank register select |
| cpu_wr_data | input | 5 | Bank number to store |
| chr_bank | output | 5 | CHR address bits 16..12 for the current fetch |

## Verification
`chr_bank` is a combinational function of the address, so a probe is compared in the same cycle that it is driven. A register write shows up one cycle after the write. A marker trigger changes the output only in cycles after the second strobed read following it, counting the triggering read as the first. The driver drives each operation on the falling edge and pushes its expected bank, computed from a requirement-level model, into a queue. The monitor pops that item and compares it against the port 1 ns later in the same low phase. This places every comparison exactly in the cycle where the result is due. Unstrobed probes read both tables between reads, which shows that each latch changes only at the second strobe, whatever address that strobe carries.

// File: rtl/chr_latch_pkg.sv
package chr_latch_pkg;

    localparam int NUM_TABLES    = 2;
    localparam int NUM_BANK_REGS = 2 * NUM_TABLES;
    localparam int REG_SEL_W     = $clog2(NUM_BANK_REGS);

    typedef enum logic {
        LATCH_FD = 1'b0,
        LATCH_FE = 1'b1
    } latch_e;

    typedef struct packed {
        logic   hit;
        logic   tbl;
        latch_e state;
    } trig_t;

    function automatic logic [REG_SEL_W-1:0] reg_index(logic tbl, logic st);
        return {tbl, st};
    endfunction

endpackage

// File: rtl/tile_trigger_decode.sv
module tile_trigger_decode
    import chr_latch_pkg::*;
#(
    parameter int          ADDR_W     = 14,
    parameter int          FINE_W     = 4,
    parameter logic [7:0]  TILE_A     = 8'hFD,
    parameter logic [7:0]  TILE_B     = 8'hFE,
    parameter logic [3:0]  T0_MASK    = 4'hF,
    parameter logic [3:0]  T0_VAL     = 4'h8,
    parameter logic [3:0]  T1_MASK    = 4'h8,
    parameter logic [3:0]  T1_VAL     = 4'h8
) (
    input  logic [ADDR_W-1:0] addr,
    output trig_t             trig
);
    localparam int SPACE_BIT = ADDR_W - 1;
    localparam int TABLE_BIT = ADDR_W - 2;
    localparam int TILE_W    = TABLE_BIT - FINE_W;

    logic [TILE_W-1:0] tile;
    logic [FINE_W-1:0] fine;
    logic              tbl;
    logic              row_ok;
    logic              is_a;
    logic              is_b;

    assign tile = addr[TABLE_BIT-1:FINE_W];
    assign fine = addr[FINE_W-1:0];
    assign tbl  = addr[TABLE_BIT];

    always_comb begin
        if (tbl) row_ok = (fine & T1_MASK) == T1_VAL;
        else     row_ok = (fine & T0_MASK) == T0_VAL;
        is_a       = tile == TILE_A;
        is_b       = tile == TILE_B;
        trig.hit   = !addr[SPACE_BIT] && row_ok && (is_a || is_b);
        trig.tbl   = tbl;
        trig.state = is_b ? LATCH_FE : LATCH_FD;
    end

endmodule

// File: rtl/trigger_pipe.sv
module trigger_pipe
    import chr_latch_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rd_strobe,
    input  trig_t                 trig_in,
    output logic [NUM_TABLES-1:0] latch_q,
    output logic                  pend_hit
);
    trig_t pend;

    always_ff @(posedge clk) begin
        if (rst)            pend <= '0;
        else if (rd_strobe) pend <= trig_in;
    end

    assign pend_hit = pend.hit;

    for (genvar t = 0; t < NUM_TABLES; t++) begin : g_table
        logic lq;
        always_ff @(posedge clk) begin
            if (rst)
                lq <= LATCH_FE;
            else if (rd_strobe && pend.hit && (pend.tbl == 1'(t)))
                lq <= pend.state;
        end
        assign latch_q[t] = lq;
    end

endmodule

// File: rtl/bank_regfile.sv
module bank_regfile
    import chr_latch_pkg::*;
#(
    parameter int BANK_W = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [REG_SEL_W-1:0] wr_sel,
    input  logic [BANK_W-1:0]    wr_data,
    output logic [BANK_W-1:0]    bank_q [NUM_BANK_REGS]
);
    for (genvar r = 0; r < NUM_BANK_REGS; r++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                bank_q[r] <= '0;
            else if (wr_en && (wr_sel == REG_SEL_W'(r)))
                bank_q[r] <= wr_data;
        end
    end

endmodule

// File: rtl/chr_tile_latch.sv
module chr_tile_latch
    import chr_latch_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int BANK_W = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    vid_addr,
    input  logic                 vid_rd,
    input  logic                 cpu_wr_en,
    input  logic [REG_SEL_W-1:0] cpu_wr_sel,
    input  logic [BANK_W-1:0]    cpu_wr_data,
    output logic [BANK_W-1:0]    chr_bank
);
    localparam int TABLE_BIT = ADDR_W - 2;

    trig_t                 trig;
    logic [NUM_TABLES-1:0] latch_q;
    logic                  pend_hit;
    logic [BANK_W-1:0]     bank_q [NUM_BANK_REGS];
    logic                  cur_tbl;

    tile_trigger_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (vid_addr),
        .trig (trig)
    );

    trigger_pipe u_pipe (
        .clk       (clk),
        .rst       (rst),
        .rd_strobe (vid_rd),
        .trig_in   (trig),
        .latch_q   (latch_q),
        .pend_hit  (pend_hit)
    );

    bank_regfile #(.BANK_W(BANK_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cpu_wr_en),
        .wr_sel  (cpu_wr_sel),
        .wr_data (cpu_wr_data),
        .bank_q  (bank_q)
    );

    assign cur_tbl  = vid_addr[TABLE_BIT];
    assign chr_bank = bank_q[reg_index(cur_tbl, latch_q[cur_tbl])];

endmodule

// File: rtl/chr_tile_latch_chk.sv
module chr_tile_latch_chk
    import chr_latch_pkg::*;
#(
    parameter int BANK_W = 5
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  vid_rd,
    input logic                  space_bit,
    input logic                  tbl_bit,
    input logic                  cpu_wr_en,
    input logic [REG_SEL_W-1:0]  cpu_wr_sel,
    input logic [BANK_W-1:0]     cpu_wr_data,
    input logic [BANK_W-1:0]     chr_bank,
    input logic [NUM_TABLES-1:0] latch_q,
    input logic                  pend_hit
);
    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (latch_q == '1) && (chr_bank == '0) && !pend_hit); // R9

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !vid_rd |=> $stable(latch_q) && $stable(pend_hit)); // R6

    AST_NO_EARLY_SWITCH: assert property (@(posedge clk) disable iff (rst)
        (vid_rd && !pend_hit) |=> $stable(latch_q)); // R7

    AST_HIGH_SPACE_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (vid_rd && space_bit) |=> !pend_hit); // R3

    AST_ONE_TABLE_MOVES: assert property (@(posedge clk) disable iff (rst)
        vid_rd |=> $countones(latch_q ^ $past(latch_q)) <= 1); // R1

    AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (rst)
        cpu_wr_en |=> (reg_index(tbl_bit, latch_q[tbl_bit]) != $past(cpu_wr_sel))
                      || (chr_bank == $past(cpu_wr_data))); // R8

endmodule

bind chr_tile_latch chr_tile_latch_chk #(.BANK_W(BANK_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .vid_rd      (vid_rd),
    .space_bit   (vid_addr[ADDR_W-1]),
    .tbl_bit     (vid_addr[ADDR_W-2]),
    .cpu_wr_en   (cpu_wr_en),
    .cpu_wr_sel  (cpu_wr_sel),
    .cpu_wr_data (cpu_wr_data),
    .chr_bank    (chr_bank),
    .latch_q     (latch_q),
    .pend_hit    (pend_hit)
);

// File: tb/chr_tile_latch_tb.sv
`timescale 1ns/1ps
module chr_tile_latch_tb;

    typedef struct {
        logic [4:0]  exp;
        logic [13:0] addr;
        string       req;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [13:0] vid_addr = '0;
    logic        vid_rd = 1'b0;
    logic        cpu_wr_en = 1'b0;
    logic [1:0]  cpu_wr_sel = '0;
    logic [4:0]  cpu_wr_data = '0;
    logic [4:0]  chr_bank;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    item_t q[$];

    logic [4:0] m_reg [4];
    logic       m_latch [2];
    logic       m_pv, m_pt, m_ps;

    always #2.5 clk = ~clk;

    chr_tile_latch u_dut (
        .clk         (clk),
        .rst         (rst),
        .vid_addr    (vid_addr),
        .vid_rd      (vid_rd),
        .cpu_wr_en   (cpu_wr_en),
        .cpu_wr_sel  (cpu_wr_sel),
        .cpu_wr_data (cpu_wr_data),
        .chr_bank    (chr_bank)
    );

    task automatic model_reset();
        for (int i = 0; i < 4; i++) m_reg[i] = '0;
        m_latch[0] = 1'b1;
        m_latch[1] = 1'b1;
        m_pv = 1'b0; m_pt = 1'b0; m_ps = 1'b0;
    endtask

    // One cycle: drive address, optionally strobe, optionally expect output.
    task automatic cyc(input logic rd, input logic [13:0] a, input string req, input bit chk);
        logic hit;
        logic row_ok;
        @(negedge clk);
        vid_rd    = rd;
        vid_addr  = a;
        cpu_wr_en = 1'b0;
        if (chk) q.push_back('{m_reg[{a[12], m_latch[a[12]]}], a, req});
        if (rd) begin
            row_ok = a[12] ? a[3] : (a[3:0] == 4'h8);           // R4 R5
            hit    = !a[13] && row_ok && (a[11:4] == 8'hFD || a[11:4] == 8'hFE);
            if (m_pv) m_latch[m_pt] = m_ps;                      // R7
            m_pv = hit;
            m_pt = a[12];
            m_ps = (a[11:4] == 8'hFE);                           // R2
        end
    endtask

    task automatic rd(input logic [13:0] a, input string req);
        cyc(1'b1, a, req, 1'b1);
    endtask

    task automatic pr(input logic [13:0] a, input string req);
        cyc(1'b0, a, req, 1'b1);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [4:0] d);
        @(negedge clk);
        vid_rd      = 1'b0;
        cpu_wr_en   = 1'b1;
        cpu_wr_sel  = sel;
        cpu_wr_data = d;
        m_reg[sel]  = d;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; vid_rd = 1'b0; cpu_wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    task automatic load_regs();
        wr(2'd0, 5'd3);
        wr(2'd1, 5'd5);
        wr(2'd2, 5'd9);
        wr(2'd3, 5'd17);
    endtask

    // Monitor: compare 1 ns after each driving edge.
    initial begin
        item_t it;
        forever begin
            @(negedge clk);
            #1;
            if (q.size() > 0) begin
                it = q.pop_front();
                checks++;
                if (chr_bank !== it.exp) begin
                    errors++;
                    $display("FAIL %s addr=%h actual=%0d expected=%0d", it.req, it.addr, chr_bank, it.exp);
                end
            end
        end
    end

    initial begin
        model_reset();
        repeat (4) @(negedge clk);
        rst = 1'b0;

        pr(14'h0000, "R9 reset regs zero");
        pr(14'h1000, "R9 reset regs zero t1");
        load_regs();
        pr(14'h0000, "R9 t0 starts FE");
        pr(14'h1FFF, "R9 t1 starts FE");

        // R2 R7: FD trigger on table 0, two-read delay
        rd(14'h0FD8, "R7 triggering read sees old");
        pr(14'h0000, "R6 unstrobed cycle keeps old");
        rd(14'h0123, "R7 second read sees old");
        pr(14'h0000, "R2 t0 now FD");
        pr(14'h1000, "R1 t1 unaffected");

        // R4: exact byte only on table 0
        rd(14'h0FE0, "R4 row0 low plane");
        rd(14'h0000, "R4 follow read");
        rd(14'h0FE9, "R4 row1");
        rd(14'h0000, "R4 follow read");
        pr(14'h0000, "R4 no switch on other rows");
        rd(14'h0FE8, "R4 exact byte");
        rd(14'h0000, "R4 follow read");
        pr(14'h0000, "R2 t0 now FE");

        // R5: table 1 any row with bit3 set
        rd(14'h1FD0, "R5 bit3 clear");
        rd(14'h1010, "R5 follow read");
        pr(14'h1000, "R5 no switch on bit3 clear");
        rd(14'h1FDB, "R5 row3 upper plane");
        rd(14'h1010, "R5 follow read");
        pr(14'h1000, "R5 t1 now FD");
        pr(14'h0000, "R1 t0 unaffected");
        rd(14'h1FEF, "R5 row7 upper plane");
        rd(14'h1010, "R5 follow read");
        pr(14'h1000, "R5 t1 back to FE");

        // R3: bit13 high never triggers
        rd(14'h2FD8, "R3 high space t0");
        rd(14'h3FDB, "R3 high space t1");
        rd(14'h0000, "R3 follow read");
        pr(14'h0000, "R3 t0 still FE");
        pr(14'h1000, "R3 t1 still FE");

        // R7: chained triggers, second read is also a marker
        rd(14'h0FD8, "R7 chain first");
        rd(14'h0FE8, "R7 chain second");
        pr(14'h0000, "R7 first applied");
        rd(14'h0000, "R7 chain third");
        pr(14'h0000, "R7 second applied");

        // R6: pending waits across idle cycles
        rd(14'h1FD8, "R6 trigger t1");
        pr(14'h1000, "R6 idle one");
        pr(14'h1000, "R6 idle two");
        rd(14'h3000, "R7 out-of-range read applies");
        pr(14'h1000, "R7 t1 now FD");

        // R8: write to selected register visible next cycle
        wr(2'd2, 5'd30);
        pr(14'h1000, "R8 selected reg updated");
        wr(2'd3, 5'd1);
        pr(14'h1000, "R8 unselected reg no effect");
        pr(14'h0000, "R8 t0 unaffected");

        // R9: reset mid-run restores FE and clears pending
        rd(14'h0FD8, "R9 pending before reset");
        do_reset();
        pr(14'h0000, "R9 regs cleared");
        load_regs();
        rd(14'h0000, "R9 pending discarded");
        pr(14'h0000, "R9 t0 FE after reset");
        pr(14'h1000, "R9 t1 FE after reset");

        repeat (3) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule